// File: doc/BRIEF.md
# Host Register Block with Software-Programmable Node Address

This block is the byte-wide host register set of a token-passing network controller. The host reaches it over a small I/O bus with an address offset, separate one-cycle read and write strobes, and separate write-data and read-data byte lanes. The block holds a configuration byte and a node address register. It also returns read-only copies of the memory-select and I/O-select switch inputs. The block decodes a group of offsets that produce a software reset, and one offset that produces a strobe for an external register.

The node-address switch inputs choose how the block behaves. When the switches are non-zero, the node address follows them and the network side is fully enabled. When the switches are all zero, the node address becomes host-programmable and the transmitter is held off. The shared RAM also stays hidden from the host until software performs a software reset and then writes a non-zero node address. Every strobe cycle counts as one access.

Top module: `nodecfg_regs`

## Requirements
- R1: After hardware reset, the configuration register reads 1CH and the node address register reads 00H. The `swrst_pulse` output is 0 and `ext_cs_n` is 1.
- R2: The configuration register is at offset 0H. A write changes it from the next cycle on, and a read returns the stored byte in the same cycle as the read strobe.
- R3: Offset 1H reads the memory-select switches and offset 2H reads the I/O-select switches, both zero-extended. Host writes to these offsets have no effect.
- R4: When the node switches are non-zero, offset 5H reads the switch value one cycle after it is applied, and host writes to 5H are ignored. In this mode `tx_en` and `ram_visible` are both 1.
- R5: When the node switches are 00H, a host write to offset 5H loads the node address register, and the new value reads back from the next cycle on.
- R6: When the node switches are 00H, `tx_en` is 0 until a non-zero value is written to 5H. It becomes 1 in the cycle after that write. Writing 00H leaves or returns it at 0.
- R7: When the node switches are 00H, `ram_visible` is 0. It becomes 1 in the cycle after a non-zero write to 5H, but only if a software reset has happened since the hardware reset and since the last such un-hiding write. A write with no preceding software reset leaves the RAM hidden.
- R8: Any read or write at offsets 8H to BH drives `swrst_pulse` to 1 for exactly the cycle after the access. The configuration and node address registers keep their values.
- R9: A write to offset 7H drives `ext_cs_n` to 0 for exactly the cycle after the write. A read of 7H leaves `ext_cs_n` at 1.
- R10: Reads of offset 7H, offsets 8H to BH and unmapped offsets (3H, 4H, 6H, CH to FH) return 00H. `rdata` is 00H whenever `rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| addr | input | ADDR_W (4) | Register offset |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data, combinational, valid while rd is high |
| node_sw | input | DATA_W (8) | Node address switch inputs |
| msel_sw | input | MSEL_W (5) | Memory-select switch inputs |
| isel_sw | input | ISEL_W (3) | I/O-select switch inputs |
| tx_en | output | 1 | Transmitter enable |
| ram_visible | output | 1 | Shared RAM visible to the host |
| swrst_pulse | output | 1 | One-cycle software reset pulse |
| ext_cs_n | output | 1 | Active-low external register select |

## Verification
Read data is combinational, so the bench samples `rdata` one nanosecond after it raises `rd` at a falling edge, still inside the strobe cycle. Register updates, `swrst_pulse`, `ext_cs_n`, and the `tx_en` and `ram_visible` flags all change at the rising edge that samples the strobe. The bench therefore checks them at the next falling edge, after it has dropped the strobe. A change on the node switches reaches the node register one edge later, so the bench lets one full cycle pass before any dependent check.

// File: rtl/hr_pkg.sv
package hr_pkg;
    localparam logic [3:0] OFS_CFG  = 4'h0;
    localparam logic [3:0] OFS_MSEL = 4'h1;
    localparam logic [3:0] OFS_ISEL = 4'h2;
    localparam logic [3:0] OFS_NODE = 4'h5;
    localparam logic [3:0] OFS_EXT  = 4'h7;
    localparam logic [3:0] OFS_RST_LO = 4'h8;
    localparam logic [3:0] OFS_RST_HI = 4'hB;

    typedef struct packed {
        logic cfg_wr;
        logic node_wr;
        logic ext_wr;
        logic swrst;
    } dec_t;
endpackage

// File: rtl/hr_decode.sv
module hr_decode
    import hr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_NODE = ADDR_W'(OFS_NODE);
    localparam logic [ADDR_W-1:0] A_EXT  = ADDR_W'(OFS_EXT);
    localparam logic [ADDR_W-1:0] A_RLO  = ADDR_W'(OFS_RST_LO);
    localparam logic [ADDR_W-1:0] A_RHI  = ADDR_W'(OFS_RST_HI);

    always_comb begin
        dec.cfg_wr  = wr && (addr == A_CFG);
        dec.node_wr = wr && (addr == A_NODE);
        dec.ext_wr  = wr && (addr == A_EXT);
        dec.swrst   = (rd || wr) && (addr >= A_RLO) && (addr <= A_RHI);
    end
endmodule

// File: rtl/hr_node_ctl.sv
module hr_node_ctl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] node_sw,
    input  logic              node_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              swrst_hit,
    output logic [DATA_W-1:0] node_val,
    output logic              tx_en,
    output logic              ram_visible
);
    typedef struct packed {
        logic [DATA_W-1:0] node;
        logic              tx_ok;
        logic              ram_ok;
        logic              armed;
    } node_st_t;

    node_st_t st_d, st_q;
    logic     sw_zero;
    logic     wr_valid;

    always_comb begin
        sw_zero  = (node_sw == '0);
        wr_valid = node_wr && (wdata != '0);
        st_d     = st_q;
        if (!sw_zero) begin
            st_d.node   = node_sw;
            st_d.tx_ok  = 1'b0;
            st_d.ram_ok = 1'b0;
        end else if (node_wr) begin
            st_d.node  = wdata;
            st_d.tx_ok = wr_valid;
            if (wr_valid && st_q.armed) begin
                st_d.ram_ok = 1'b1;
                st_d.armed  = 1'b0;
            end
        end
        if (swrst_hit) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign node_val    = st_q.node;
    assign tx_en       = !sw_zero || st_q.tx_ok;
    assign ram_visible = !sw_zero || st_q.ram_ok;
endmodule

// File: rtl/hr_rdmux.sv
module hr_rdmux
    import hr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int MSEL_W = 5,
    parameter int ISEL_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic [DATA_W-1:0] cfg,
    input  logic [MSEL_W-1:0] msel,
    input  logic [ISEL_W-1:0] isel,
    input  logic [DATA_W-1:0] node,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == ADDR_W'(OFS_CFG)) begin
                rdata = cfg;
            end else if (addr == ADDR_W'(OFS_MSEL)) begin
                rdata = DATA_W'(msel);
            end else if (addr == ADDR_W'(OFS_ISEL)) begin
                rdata = DATA_W'(isel);
            end else if (addr == ADDR_W'(OFS_NODE)) begin
                rdata = node;
            end
        end
    end
endmodule

// File: rtl/nodecfg_regs.sv
module nodecfg_regs
    import hr_pkg::*;
#(
    parameter int          ADDR_W  = 4,
    parameter int          DATA_W  = 8,
    parameter int          MSEL_W  = 5,
    parameter int          ISEL_W  = 3,
    parameter logic [7:0]  CFG_RST = 8'h1C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] node_sw,
    input  logic [MSEL_W-1:0] msel_sw,
    input  logic [ISEL_W-1:0] isel_sw,
    output logic              tx_en,
    output logic              ram_visible,
    output logic              swrst_pulse,
    output logic              ext_cs_n
);
    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic              swrst;
        logic              ext_n;
    } top_st_t;

    dec_t              dec;
    top_st_t           st_d, st_q;
    logic [DATA_W-1:0] node_val;
    logic [DATA_W-1:0] cfg_q;

    hr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .rd   (rd),
        .wr   (wr),
        .dec  (dec)
    );

    hr_node_ctl #(.DATA_W(DATA_W)) u_node (
        .clk         (clk),
        .rst_n       (rst_n),
        .node_sw     (node_sw),
        .node_wr     (dec.node_wr),
        .wdata       (wdata),
        .swrst_hit   (dec.swrst),
        .node_val    (node_val),
        .tx_en       (tx_en),
        .ram_visible (ram_visible)
    );

    always_comb begin
        st_d       = st_q;
        st_d.swrst = dec.swrst;
        st_d.ext_n = !dec.ext_wr;
        if (dec.cfg_wr) begin
            st_d.cfg = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg   <= DATA_W'(CFG_RST);
            st_q.swrst <= 1'b0;
            st_q.ext_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q       = st_q.cfg;
    assign swrst_pulse = st_q.swrst;
    assign ext_cs_n    = st_q.ext_n;

    hr_rdmux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MSEL_W (MSEL_W),
        .ISEL_W (ISEL_W)
    ) u_rd (
        .addr  (addr),
        .rd    (rd),
        .cfg   (cfg_q),
        .msel  (msel_sw),
        .isel  (isel_sw),
        .node  (node_val),
        .rdata (rdata)
    );
endmodule

// File: rtl/hr_regs_chk.sv
module hr_regs_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd,
    input logic              wr,
    input logic [DATA_W-1:0] node_sw,
    input logic [DATA_W-1:0] cfg_q,
    input logic              tx_en,
    input logic              ram_visible,
    input logic              swrst_pulse,
    input logic              ext_cs_n
);
    logic rst_acc;
    logic ext_wr;
    logic node_wr;
    logic cfg_wr;

    assign rst_acc = (rd || wr) && (addr >= ADDR_W'(8)) && (addr <= ADDR_W'(11));
    assign ext_wr  = wr && (addr == ADDR_W'(7));
    assign node_wr = wr && (addr == ADDR_W'(5));
    assign cfg_wr  = wr && (addr == ADDR_W'(0));

    // R8
    swrst_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_acc |=> swrst_pulse);

    // R8
    swrst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_acc |=> !swrst_pulse);

    // R9
    extcs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |=> !ext_cs_n);

    // R9
    extcs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr |=> ext_cs_n);

    // R6
    tx_held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (node_sw == '0 && !tx_en && !node_wr) |=> (node_sw != '0 || !tx_en));

    // R7
    ram_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (node_sw == '0 && !ram_visible && !node_wr) |=> (node_sw != '0 || !ram_visible));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_q));

    // R4
    sw_set_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (node_sw != '0) |-> (tx_en && ram_visible));
endmodule

bind nodecfg_regs hr_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .rd          (rd),
    .wr          (wr),
    .node_sw     (node_sw),
    .cfg_q       (cfg_q),
    .tx_en       (tx_en),
    .ram_visible (ram_visible),
    .swrst_pulse (swrst_pulse),
    .ext_cs_n    (ext_cs_n)
);

// File: tb/nodecfg_regs_test.sv
`timescale 1ns/1ps
module nodecfg_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] node_sw = '0;
    logic [4:0] msel_sw = 5'h15;
    logic [2:0] isel_sw = 3'h6;
    logic       tx_en, ram_visible, swrst_pulse, ext_cs_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_cfg, m_node;
    bit m_tx, m_ram, m_arm;

    always #2 clk = ~clk;

    nodecfg_regs uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .node_sw(node_sw), .msel_sw(msel_sw),
        .isel_sw(isel_sw), .tx_en(tx_en), .ram_visible(ram_visible),
        .swrst_pulse(swrst_pulse), .ext_cs_n(ext_cs_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return m_cfg;
            4'h1: return {3'b0, msel_sw};
            4'h2: return {5'b0, isel_sw};
            4'h5: return m_node;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit is_rst(input logic [3:0] a);
        return (a >= 4'h8) && (a <= 4'hB);
    endfunction

    // advance the model by one strobe cycle
    task automatic model_step(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d);
        if (w && a == 4'h0) m_cfg = d;
        if (node_sw != 0) begin
            m_node = node_sw; m_tx = 0; m_ram = 0;
        end else if (w && a == 4'h5) begin
            m_node = d;
            m_tx = (d != 0);
            if (d != 0 && m_arm) begin m_ram = 1; m_arm = 0; end
        end
        if ((w || r) && is_rst(a)) m_arm = 1;
    endtask

    task automatic check_outs(input bit w, input bit r, input logic [3:0] a);
        check("R8 swrst_pulse", {7'b0, swrst_pulse}, {7'b0, (w || r) && is_rst(a)});
        check("R9 ext_cs_n", {7'b0, ext_cs_n}, {7'b0, !(w && a == 4'h7)});
        check("R6 tx_en", {7'b0, tx_en}, {7'b0, (node_sw != 0) || m_tx});
        check("R7 ram_visible", {7'b0, ram_visible}, {7'b0, (node_sw != 0) || m_ram});
    endtask

    task automatic access(input bit w, input logic [3:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        addr = a; wdata = d; wr = w; rd = !w;
        #1;
        if (!w) check(tag, rdata, exp_rd(a));
        @(negedge clk);
        wr = 0; rd = 0;
        model_step(w, !w, a, d);
        check_outs(w, !w, a);
    endtask

    task automatic set_sw(input logic [7:0] v);
        @(negedge clk);
        node_sw = v;
        @(negedge clk);
        model_step(0, 0, 4'h0, 8'h00);
        check_outs(0, 0, 4'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5eed);
        m_cfg = 8'h1C; m_node = 8'h00; m_tx = 0; m_ram = 0; m_arm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 swrst_pulse", {7'b0, swrst_pulse}, 8'h00);
        check("R1 ext_cs_n", {7'b0, ext_cs_n}, 8'h01);
        check("R1 tx_en", {7'b0, tx_en}, 8'h00);
        check("R1 ram_visible", {7'b0, ram_visible}, 8'h00);
        access(0, 4'h0, 8'h00, "R1 cfg reset");
        access(0, 4'h5, 8'h00, "R1 node reset");
        // R2 config
        access(1, 4'h0, 8'hA5, "R2");
        access(0, 4'h0, 8'h00, "R2 cfg readback");
        // R3 switch copies ignore writes
        access(1, 4'h1, 8'hFF, "R3");
        access(1, 4'h2, 8'hFF, "R3");
        access(0, 4'h1, 8'h00, "R3 msel read");
        access(0, 4'h2, 8'h00, "R3 isel read");
        // R6 R7: write 00 then non-zero without software reset
        access(1, 4'h5, 8'h00, "R6 zero write");
        access(1, 4'h5, 8'h33, "R7 no-arm write");
        access(0, 4'h5, 8'h00, "R5 node readback");
        // R8 software reset, then R7 sequence
        access(0, 4'h9, 8'h00, "R10 reset read");
        access(0, 4'h0, 8'h00, "R8 cfg kept");
        access(1, 4'h5, 8'h00, "R7 armed zero write");
        access(1, 4'h5, 8'h44, "R7 armed valid write");
        access(0, 4'h5, 8'h00, "R5 node readback");
        // R9 external strobe
        access(0, 4'h7, 8'h00, "R9 read 7");
        access(1, 4'h7, 8'h5A, "R9");
        // R4 non-zero switches
        set_sw(8'h2B);
        access(1, 4'h5, 8'h77, "R4");
        access(0, 4'h5, 8'h00, "R4 node reads switches");
        access(1, 4'hB, 8'h01, "R8 write reset");
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] a;
            logic [7:0] d;
            bit w;
            if ((i % 16) == 0) set_sw(($urandom % 3 == 0) ? 8'h00 : 8'($urandom));
            a = 4'($urandom);
            d = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            w = $urandom % 2;
            msel_sw = 5'($urandom);
            isel_sw = 3'($urandom);
            access(w, a, d, w ? "R5 random write" : "R10 random read");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule